// File: doc/BRIEF.md
# Block Transfer Bounds Checker

This block decides whether a two-dimensional block transfer can run against video memory without touching anything outside it. A request gives the line width in bytes, the number of lines, and a start address and signed line pitch for each of the destination and source regions. It also gives an address mask and a memory size select. The caller pulses `start` with the request fields held stable. One clock later the block pulses `valid` and presents a registered `unsafe` verdict. The transfer engine must drop any request that comes back unsafe.

The source and destination regions are judged independently by the same rule. Each start address is masked first. The rule depends on the pitch sign:
- A forward (positive) pitch bounds the far end of the last line.
- A backward (negative) pitch bounds the lowest line at zero and the first line's end at the memory size.

Every product and sum is formed in a signed intermediate wide enough that no combination of inputs can wrap.

Top module: `blit_bounds_check`

## Requirements
- R1: `valid` is high in exactly the cycle after a cycle in which `start` was sampled high, and low otherwise.
- R2: After reset `valid` and `unsafe` are 0. `unsafe` keeps its last verdict until the next request is evaluated, whatever the inputs do in between.
- R3: A request with zero width or zero height is unsafe.
- R4: A request whose width exceeds `LBUF_BYTES` (8192 by default) is unsafe. A width equal to `LBUF_BYTES` is allowed.
- R5: A region with a pitch of zero makes the request unsafe.
- R6: For a positive pitch, a region is bad when masked_start + (height−1)·pitch + width > memory size. Equality is allowed.
- R7: For a negative pitch, a region is bad when masked_start + (height−1)·pitch < 0, or when masked_start + width > memory size.
- R8: Each start address is ANDed with `addr_mask` before any bound is computed.
- R9: Destination and source are checked by the same rule. The request is unsafe when either region is bad.
- R10: The memory size is set by `mem_sel` as follows: 0 selects 2^(ADDR_W−2) bytes, 1 selects 2^(ADDR_W−1) bytes, and 2 selects 2^ADDR_W bytes. With the default ADDR_W of 24 these are 4, 8 and 16 MiB. `mem_sel` = 3 makes every request unsafe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the request on the inputs this cycle |
| width | input | WID_W | Line width in bytes |
| height | input | HGT_W | Number of lines |
| dst_addr | input | ADDR_W | Destination start address |
| dst_pitch | input | PITCH_W | Destination pitch, two's complement |
| src_addr | input | ADDR_W | Source start address |
| src_pitch | input | PITCH_W | Source pitch, two's complement |
| addr_mask | input | ADDR_W | Mask applied to both start addresses |
| mem_sel | input | 2 | Memory size select |
| valid | output | 1 | Verdict strobe, one cycle after start |
| unsafe | output | 1 | Registered verdict, 1 means suppress |

## Verification
The bench builds the block with its default parameters:
- ADDR_W 24 reaches all three memory sizes up to 16 MiB.
- WID_W 14 lets widths run just past the 8192-byte line buffer.
- HGT_W 11 and PITCH_W 16 allow a line offset of about ±67 million bytes, which probes the wide signed intermediate at both extremes.

Random requests bias widths, pitches and addresses toward the bounds. Directed cases land exactly on and one past each limit, and include a case where the mask rescues an address that would otherwise fail.

// File: rtl/blit_bounds_check.sv
module blit_bounds_check #(
  parameter int ADDR_W     = 24,
  parameter int WID_W      = 14,
  parameter int HGT_W      = 11,
  parameter int PITCH_W    = 16,
  parameter int LBUF_BYTES = 8192
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [WID_W-1:0]          width,
  input  logic [HGT_W-1:0]          height,
  input  logic [ADDR_W-1:0]         dst_addr,
  input  logic signed [PITCH_W-1:0] dst_pitch,
  input  logic [ADDR_W-1:0]         src_addr,
  input  logic signed [PITCH_W-1:0] src_pitch,
  input  logic [ADDR_W-1:0]         addr_mask,
  input  logic [1:0]                mem_sel,
  output logic                      valid,
  output logic                      unsafe
);
  localparam int CW = ADDR_W + HGT_W + PITCH_W + 4;

  logic signed [CW-1:0] w_ext, span, mem_bytes, lbuf;
  logic bad_dims, bad_dst, bad_src, verdict;

  assign w_ext = $signed({{(CW-WID_W){1'b0}}, width});
  assign span  = $signed({{(CW-HGT_W){1'b0}}, height}) - CW'(1);
  assign lbuf  = CW'(LBUF_BYTES);

  always_comb begin
    mem_bytes = '0;
    case (mem_sel)
      2'd0:    mem_bytes[ADDR_W-2] = 1'b1;
      2'd1:    mem_bytes[ADDR_W-1] = 1'b1;
      default: mem_bytes[ADDR_W]   = 1'b1;
    endcase
  end

  function automatic logic region_bad(input logic [ADDR_W-1:0] addr,
                                      input logic signed [PITCH_W-1:0] pitch,
                                      input logic signed [CW-1:0] lines_m1,
                                      input logic signed [CW-1:0] wbytes,
                                      input logic signed [CW-1:0] limit,
                                      input logic [ADDR_W-1:0] mask);
    logic signed [CW-1:0] base, step, reach;
    base  = $signed({{(CW-ADDR_W){1'b0}}, addr & mask});
    step  = $signed({{(CW-PITCH_W){pitch[PITCH_W-1]}}, pitch});
    reach = base + lines_m1 * step;
    if (pitch == '0)
      return 1'b1;
    else if (pitch[PITCH_W-1])
      return (reach < 0) || (base + wbytes > limit);
    else
      return reach + wbytes > limit;
  endfunction

  assign bad_dims = (width == '0) || (height == '0) || (w_ext > lbuf) || (mem_sel == 2'd3);
  assign bad_dst  = region_bad(dst_addr, dst_pitch, span, w_ext, mem_bytes, addr_mask);
  assign bad_src  = region_bad(src_addr, src_pitch, span, w_ext, mem_bytes, addr_mask);
  assign verdict  = bad_dims || bad_dst || bad_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      unsafe <= 1'b0;
    end else begin
      valid <= start;
      if (start) unsafe <= verdict;
    end
  end
endmodule

// File: rtl/blit_bounds_check_sva.sv
module blit_bounds_check_sva #(
  parameter int WID_W      = 14,
  parameter int HGT_W      = 11,
  parameter int PITCH_W    = 16,
  parameter int LBUF_BYTES = 8192
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [WID_W-1:0]          width,
  input logic [HGT_W-1:0]          height,
  input logic signed [PITCH_W-1:0] dst_pitch,
  input logic signed [PITCH_W-1:0] src_pitch,
  input logic [1:0]                mem_sel,
  input logic                      valid,
  input logic                      unsafe
);
  p_valid_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  p_valid_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start));
  p_verdict_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(unsafe));
  p_zero_dims_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (width == '0 || height == '0)) |=> unsafe);
  p_too_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && 32'(width) > LBUF_BYTES) |=> unsafe);
  p_zero_pitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (dst_pitch == '0 || src_pitch == '0)) |=> unsafe);
  p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_sel == 2'd3) |=> unsafe);
endmodule

bind blit_bounds_check blit_bounds_check_sva #(
  .WID_W(WID_W), .HGT_W(HGT_W), .PITCH_W(PITCH_W), .LBUF_BYTES(LBUF_BYTES)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
  .dst_pitch(dst_pitch), .src_pitch(src_pitch), .mem_sel(mem_sel),
  .valid(valid), .unsafe(unsafe)
);

// File: tb/blit_bounds_check_tb_top.sv
module blit_bounds_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [13:0] width = '0;
  logic [10:0] height = '0;
  logic [23:0] dst_addr = '0, src_addr = '0, addr_mask = '1;
  logic signed [15:0] dst_pitch = '0, src_pitch = '0;
  logic [1:0] mem_sel = '0;
  logic valid, unsafe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  blit_bounds_check dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
    .dst_addr(dst_addr), .dst_pitch(dst_pitch), .src_addr(src_addr),
    .src_pitch(src_pitch), .addr_mask(addr_mask), .mem_sel(mem_sel),
    .valid(valid), .unsafe(unsafe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit region_bad(longint a, longint p, longint w, longint h, longint size);
    if (p == 0) return 1;
    if (p < 0) return (a + (h - 1) * p < 0) || (a + w > size);
    return a + (h - 1) * p + w > size;
  endfunction

  function automatic bit model();
    longint size, m;
    if (width == 0 || height == 0) return 1;
    if (width > 8192) return 1;
    if (mem_sel == 3) return 1;
    size = longint'(1) << (22 + mem_sel);
    m = longint'(addr_mask);
    return region_bad(longint'(dst_addr) & m, longint'(dst_pitch), longint'(width), longint'(height), size) ||
           region_bad(longint'(src_addr) & m, longint'(src_pitch), longint'(width), longint'(height), size);
  endfunction

  task automatic run(input string req);
    bit exp;
    bit held;
    exp = model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(valid == 1'b1, {req, " valid R1"}, valid, 1);
    check(unsafe == exp, req, unsafe, exp);
    held = unsafe;
    width = 14'($urandom); dst_pitch = 16'($urandom); mem_sel = 2'($urandom);
    @(negedge clk);
    check(valid == 1'b0, "R1 single pulse", valid, 0);
    check(unsafe == held, "R2 hold", unsafe, held);
  endtask

  task automatic setup(input int w, input int h, input int da, input int dp,
                       input int sa, input int sp, input int mask, input int ms);
    width = 14'(w); height = 11'(h); dst_addr = 24'(da); dst_pitch = 16'(dp);
    src_addr = 24'(sa); src_pitch = 16'(sp); addr_mask = 24'(mask); mem_sel = 2'(ms);
  endtask

  initial begin
    void'($urandom(32'd5417));
    repeat (3) @(negedge clk);
    check(valid == 0 && unsafe == 0, "R2 reset", {valid, unsafe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    setup(16, 4, 4194096, 64, 0, 16, 24'hFFFFFF, 0); run("R6 exact fit");
    setup(16, 4, 4194097, 64, 0, 16, 24'hFFFFFF, 0); run("R6 one past");
    setup(16, 4, 192, -64, 0, 16, 24'hFFFFFF, 0); run("R7 low edge ok");
    setup(16, 4, 191, -64, 0, 16, 24'hFFFFFF, 0); run("R7 below zero");
    setup(16, 4, 4194288, -64, 0, 16, 24'hFFFFFF, 0); run("R7 top ok");
    setup(16, 4, 4194289, -64, 0, 16, 24'hFFFFFF, 0); run("R7 top past");
    setup(16, 1, 24'hFFFFF0, 16, 24'hFFFFF0, 16, 24'h3FFFFF, 0); run("R8 mask rescues");
    setup(16, 1, 24'hFFFFF0, 16, 0, 16, 24'hFFFFFF, 0); run("R8 unmasked fails");
    setup(16, 2, 0, 64, 0, 0, 24'hFFFFFF, 0); run("R5 R9 src pitch zero");
    setup(16, 2, 0, 0, 0, 64, 24'hFFFFFF, 0); run("R5 dst pitch zero");
    setup(16, 8, 0, 64, 100, -64, 24'hFFFFFF, 0); run("R9 src below zero");
    setup(8192, 1, 0, 8192, 0, 8192, 24'hFFFFFF, 2); run("R4 width at limit");
    setup(8193, 1, 0, 8192, 0, 8192, 24'hFFFFFF, 2); run("R4 width over");
    setup(0, 4, 0, 64, 0, 64, 24'hFFFFFF, 1); run("R3 zero width");
    setup(16, 0, 0, 64, 0, 64, 24'hFFFFFF, 1); run("R3 zero height");
    setup(16, 4, 0, 64, 0, 64, 24'hFFFFFF, 3); run("R10 reserved size");
    setup(16, 2047, 24'hFFFFFF, -32768, 0, 64, 24'hFFFFFF, 2); run("R7 extreme negative");
    setup(16, 2047, 0, 32767, 0, 64, 24'hFFFFFF, 2); run("R6 extreme positive");
    setup(16, 200, 8388608, 32767, 0, 64, 24'hFFFFFF, 1); run("R10 8MiB top");

    for (int i = 0; i < 500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      width = (sel == 0) ? 14'($urandom_range(8000, 9000)) : 14'($urandom_range(0, 300));
      height = (sel == 1) ? 11'($urandom) : 11'($urandom_range(0, 64));
      dst_pitch = (sel == 2) ? 16'sd0 : 16'($signed(int'($urandom_range(0, 8192)) - 4096));
      src_pitch = (sel == 3) ? 16'($urandom) : 16'($signed(int'($urandom_range(0, 8192)) - 4096));
      dst_addr = (sel < 5) ? 24'($urandom) : 24'(($urandom_range(0, 1) != 0) ? $urandom_range(0, 20000) : 32'h400000 - $urandom_range(0, 20000));
      src_addr = 24'($urandom);
      case ($urandom_range(0, 2))
        0: addr_mask = 24'hFFFFFF;
        1: addr_mask = 24'h3FFFFF;
        default: addr_mask = 24'h7FFFFF;
      endcase
      mem_sel = 2'($urandom_range(0, 3));
      run("R6 R7 R9 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule